// File: doc/BRIEF.md
# Dual-Address Control Register

This block is a memory-mapped slave that holds a single 32-bit control word and makes it reachable at two bus addresses. The word carries two 8-bit fields. The low field sits in bits 7:0 and the high field in bits 23:16. Each address applies its own write policy. The primary address at 0x000 can change only the low field. The full-access address at 0x100 can change both fields.

Both addresses share one copy of the storage, so software can use either address to read back what the other wrote. The bus is a plain synchronous one: a write takes effect at the clock edge and read data is registered. Any access to an address other than the two mapped ones raises an error flag in the same cycle and has no effect on the storage.

Top module: `alias_ctl_reg`

## Requirements
- R1: After an active-low reset, both fields are zero and `rd_data` is zero.
- R2: A write to 0x000 loads `wr_data[7:0]` into the low field and leaves the high field unchanged.
- R3: A write to 0x100 loads `wr_data[7:0]` into the low field and `wr_data[23:16]` into the high field.
- R4: Both addresses read the same storage: a read at 0x000 or 0x100 returns the low field in bits 7:0 and the high field in bits 23:16.
- R5: Bits 15:8 and 31:24 of read data are always zero, and write data in those bits has no effect at either address.
- R6: Read data is registered. `rd_data` shows the value one clock after a cycle with `rd_en` high, and shows zero one clock after a cycle with `rd_en` low.
- R7: In any cycle where `wr_en` or `rd_en` is high and the address is neither 0x000 nor 0x100, `err` is high in that same cycle. Such a write changes no field, and such a read returns zero. `err` is low in all other cycles.
- R8: When `wr_en` and `rd_en` are high in the same cycle at a mapped address, the read returns the field values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data word |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| err | output | 1 | Error response for an unmapped access (same cycle) |

## Verification
A write and a read can fall in the same cycle. The bench provokes this by asserting `wr_en` and `rd_en` together at the full-access address with data that differs from the stored value. It then checks that the registered read returns the old word, and that the next plain read returns the new word. Unmapped accesses are also checked: the bench places them between known writes and reads, confirms `err` during the access cycle, and reads back both fields afterwards to show that neither changed.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int WORD_W = 32;
  localparam int FLD_W  = 8;
  localparam int FLD_N  = 2;

  typedef logic [FLD_W-1:0]  fld_t;
  typedef logic [WORD_W-1:0] word_t;

  // bit position of each field inside the word
  function automatic int fld_lsb(input int k);
    return (k == 0) ? 0 : 16;
  endfunction

  function automatic fld_t get_fld(input word_t w, input int k);
    return w[fld_lsb(k) +: FLD_W];
  endfunction

  // assemble a read word; unused bits stay zero
  function automatic word_t put_flds(input fld_t lo, input fld_t hi);
    word_t w;
    w = '0;
    w[fld_lsb(0) +: FLD_W] = lo;
    w[fld_lsb(1) +: FLD_W] = hi;
    return w;
  endfunction
endpackage

// File: rtl/acr_decode.sv
module acr_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PRI_ADDR  = 'h000,
  parameter logic [ADDR_W-1:0] FULL_ADDR = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              wr_pri,
  output logic              wr_full,
  output logic              rd_hit,
  output logic              miss
);
  logic hit_pri, hit_full, access;

  assign hit_pri  = (addr == PRI_ADDR);
  assign hit_full = (addr == FULL_ADDR);
  assign access   = wr_en | rd_en;
  assign wr_pri   = wr_en & hit_pri;
  assign wr_full  = wr_en & hit_full;
  assign rd_hit   = rd_en & (hit_pri | hit_full);
  assign miss     = access & ~(hit_pri | hit_full);

  AST_DECODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_pri, wr_full, miss & wr_en})); // R7
  AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> !rd_hit); // R7
endmodule

// File: rtl/acr_fields.sv
module acr_fields
  import acr_pkg::*;
#(
  // per-field write permission through the primary address
  parameter logic [FLD_N-1:0] PRI_WR_MASK = 2'b01
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_pri,
  input  logic                        wr_full,
  input  word_t                       wr_data,
  output logic [FLD_N-1:0][FLD_W-1:0] fld_q
);
  logic [FLD_N-1:0] fld_we;

  for (genvar k = 0; k < FLD_N; k++) begin : g_fld
    assign fld_we[k] = wr_full | (wr_pri & PRI_WR_MASK[k]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fld_q[k] <= '0;
      else if (fld_we[k]) fld_q[k] <= get_fld(wr_data, k);
    end
  end

  AST_PRI_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pri && !wr_full) |=> $stable(fld_q[1])); // R2
  AST_FULL_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |=> fld_q[1] == $past(wr_data[23:16])); // R3
  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pri || wr_full) |=> fld_q[0] == $past(wr_data[7:0])); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pri && !wr_full) |=> $stable(fld_q)); // R7
endmodule

// File: rtl/acr_rdata.sv
module acr_rdata
  import acr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_hit,
  input  logic [FLD_N-1:0][FLD_W-1:0] fld_q,
  output word_t                       rd_data
);
  word_t rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_hit) rd_q <= put_flds(fld_q[0], fld_q[1]);
    else             rd_q <= '0;
  end

  assign rd_data = rd_q;

  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:8] == '0) && (rd_data[31:24] == '0)); // R5
  AST_NOREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> rd_data == '0); // R6
endmodule

// File: rtl/alias_ctl_reg.sv
module alias_ctl_reg
  import acr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PRI_ADDR  = 'h000,
  parameter logic [ADDR_W-1:0] FULL_ADDR = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              err
);
  logic wr_pri, wr_full, rd_hit, miss;
  logic [FLD_N-1:0][FLD_W-1:0] fld_q;

  acr_decode #(
    .ADDR_W(ADDR_W), .PRI_ADDR(PRI_ADDR), .FULL_ADDR(FULL_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_pri(wr_pri), .wr_full(wr_full), .rd_hit(rd_hit), .miss(miss)
  );

  acr_fields #(.PRI_WR_MASK(2'b01)) u_fld (
    .clk(clk), .rst_n(rst_n), .wr_pri(wr_pri), .wr_full(wr_full),
    .wr_data(wr_data), .fld_q(fld_q)
  );

  acr_rdata u_rd (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .fld_q(fld_q),
    .rd_data(rd_data)
  );

  assign err = miss;

  AST_MISS_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && err) |=> $stable(fld_q)); // R7
  AST_MISS_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && err) |=> rd_data == '0); // R7
  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (wr_en || rd_en)); // R7
endmodule

// File: tb/alias_ctl_reg_tb.sv
module alias_ctl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  alias_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .err(err)
  );

  // op: 1 write, 2 read, 3 write+read
  localparam int NV = 16;
  localparam logic [1:0]  VOP  [NV] = '{2,2,1,2,2,1,2,1,2,1,2,2,1,3,2,2};
  localparam logic [11:0] VADR [NV] = '{
    12'h000, 12'h100, 12'h000, 12'h000, 12'h100, 12'h100, 12'h000, 12'h000,
    12'h100, 12'h004, 12'h004, 12'h100, 12'h101, 12'h100, 12'h000, 12'h080};
  localparam logic [31:0] VWD  [NV] = '{
    32'h0, 32'h0, 32'hFFFF_FFAA, 32'h0, 32'h0, 32'h1234_5678, 32'h0, 32'h0099_0011,
    32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h00C3_00B2, 32'h0, 32'h0};
  localparam logic [31:0] VRD  [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0000_00AA, 32'h0000_00AA, 32'h0, 32'h0034_0078, 32'h0,
    32'h0034_0011, 32'h0, 32'h0, 32'h0034_0011, 32'h0, 32'h0034_0011, 32'h00C3_00B2, 32'h0};
  localparam logic        VERR [NV] = '{0,0,0,0,0,0,0,0,0,1,1,0,1,0,0,1};
  // requirement number each vector exercises:
  // R1 R1 R2 R2 R4 R3 R3 R2 R4 R7 R7 R7 R7 R8 R8 R7
  localparam int          VREQ [NV] = '{1,1,2,2,4,3,3,2,4,7,7,7,7,8,8,7};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [11:0] a, input logic [31:0] wd,
                        input logic exp_err, input logic [31:0] exp_rd, input string req);
    @(negedge clk);
    addr = a; wr_data = wd; wr_en = op[0]; rd_en = op[1];
    #1;
    chk({req, " err"}, {31'b0, err}, {31'b0, exp_err});
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
    if (op[1]) chk({req, " rd_data"}, rd_data, exp_rd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rd_data", rd_data, 32'h0);
    chk("R1 reset err", {31'b0, err}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      access(VOP[i], VADR[i], VWD[i], VERR[i], VRD[i], $sformatf("R%0d vec%0d", VREQ[i], i));

    // R6: cycle without read clears rd_data
    access(2'd2, 12'h100, 32'h0, 1'b0, 32'h00C3_00B2, "R6 read");
    access(2'd0, 12'h100, 32'h0, 1'b0, 32'h0, "R6 idle");
    chk("R6 idle rd_data", rd_data, 32'h0);
    // R6: data not visible before the edge
    @(negedge clk);
    addr = 12'h000; rd_en = 1'b1;
    #1;
    chk("R6 pre-edge rd_data", rd_data, 32'h0);
    @(posedge clk);
    #1;
    rd_en = 1'b0;
    chk("R6 post-edge rd_data", rd_data, 32'h00C3_00B2);

    // R5: reserved bits written at both addresses, read back zero
    access(2'd1, 12'h100, 32'hA5EE_5A11, 1'b0, 32'h0, "R5 write");
    access(2'd2, 12'h000, 32'h0, 1'b0, 32'h00EE_0011, "R5 read");
    access(2'd1, 12'h000, 32'hFFFF_FF22, 1'b0, 32'h0, "R5 write pri");
    access(2'd2, 12'h100, 32'h0, 1'b0, 32'h00EE_0022, "R5 read full");

    // R7: unmapped address with no strobe gives no error
    access(2'd0, 12'h0FC, 32'h0, 1'b0, 32'h0, "R7 idle unmapped");

    // R1: reset in mid-run clears the stored fields
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async rd_data", rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    access(2'd2, 12'h100, 32'h0, 1'b0, 32'h0, "R1 after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule